// File: doc/BRIEF.md
# Parallel-Concatenated Turbo Convolutional Encoder

This block turns a serial stream of data bits into a turbo code. Bits arrive one per cycle with a valid strobe. The first bit of a block carries a start strobe, and a size select chooses between a short and a long block. The bits are written into one half of a two-half block store. When a half is full and the encoding engine is free, the engine reads that half twice per cycle. One read uses natural order and feeds the first constituent encoder. The other read uses a row-column permuted order and feeds the second constituent encoder. Both encoders read the same stored block in the same cycles, so their systematic streams leave aligned to the same block boundary. While one block is being encoded, the other half can fill.

Each constituent encoder is a recursive systematic convolutional encoder with a 3-bit state. Per data bit it emits one systematic bit and two parity bits. After the last data bit it runs three termination cycles that drive its state back to zero, and it presents the termination input bits on a separate tail output. No bits are removed: every systematic, parity and tail bit appears at the outputs. A synchronous clear drops all stored and in-flight work.

Top module: `turbo_pcc_encoder`

## Requirements
- R1: After reset `ready` is 1 and `out_valid` is 0. `ready` is 1 exactly when the half being written can take data, and it goes to 0 once both halves hold blocks that have not yet been encoded.
- R2: `size_sel`, sampled with the bit that has `in_first` set, sets the block length: 0 gives 16 bits and 1 gives 48 bits.
- R3: For each block, `out_valid` is 1 for exactly L+3 consecutive cycles, where L is the block length. While `out_valid` is 0, all eight encoded outputs are 0.
- R4: During the data cycles, `nat_sys` carries the block bits in arrival order.
- R5: During data cycle k (counted from 0), `il_sys` carries the input bit with index (k mod 4)*(L/4) + floor(k/4).
- R6: Each encoder has a state (s1,s2,s3) that is 0 at block start. With input u, let w = u^s2^s3. Then par0 = w^s1^s3 and par1 = w^s1^s2^s3. After that the state shifts: s3<=s2, s2<=s1, s1<=w.
- R7: After the data cycles come 3 termination cycles. In each one the encoder input is s2^s3, which is shown on its tail output while its systematic output is 0. Tail outputs are 0 during data cycles. After the third termination cycle the state is zero.
- R8: A second block can be written while the first is being encoded, and both are encoded in order. Input presented while `ready` is 0, including a start strobe, is ignored.
- R9: When `clr` is asserted, `out_valid` is 0 and `ready` is 1 on the next cycle. Partially written and pending blocks are discarded, and the next block encodes from the zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of buffers and encoders |
| in_bit | input | 1 | Serial data bit |
| in_valid | input | 1 | Data bit strobe |
| in_first | input | 1 | Marks the first bit of a block |
| size_sel | input | 1 | Block length select, sampled with in_first |
| ready | output | 1 | Write half can accept data |
| out_valid | output | 1 | Encoded outputs valid |
| nat_sys | output | 1 | Natural-order encoder systematic bit |
| nat_par0 | output | 1 | Natural-order encoder parity 0 |
| nat_par1 | output | 1 | Natural-order encoder parity 1 |
| nat_tail | output | 1 | Natural-order encoder termination bit |
| il_sys | output | 1 | Interleaved encoder systematic bit |
| il_par0 | output | 1 | Interleaved encoder parity 0 |
| il_par1 | output | 1 | Interleaved encoder parity 1 |
| il_tail | output | 1 | Interleaved encoder termination bit |

## Verification
The assertions check on every cycle that the outputs are quiet while idle, that each valid run has the length the latched size select calls for, and that tail bits appear only in termination cycles. They also check that the termination cycles leave both encoder states at zero, that `ready` drops only when both halves are occupied, and that a clear idles the block on the next cycle. The bench scenarios are needed to show the actual bit values: the parity recursion, the permuted read order, that input refused while `ready` is low does not corrupt either stored block, and that work discarded by a clear leaves no trace in the next block.

// File: rtl/tpe_pkg.sv
`timescale 1ns/1ps
package tpe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_TAIL = 2'd2
  } tpe_phase_e;

  // state vector: s[0] = newest delay element, s[2] = oldest
  function automatic logic rsc_fb(input logic [2:0] s);
    return s[1] ^ s[2];
  endfunction

  function automatic logic rsc_w(input logic [2:0] s, input logic u);
    return u ^ rsc_fb(s);
  endfunction

  function automatic logic [2:0] rsc_next(input logic [2:0] s, input logic u);
    return {s[1], s[0], rsc_w(s, u)};
  endfunction

  function automatic logic rsc_par0(input logic [2:0] s, input logic u);
    return rsc_w(s, u) ^ s[0] ^ s[2];
  endfunction

  function automatic logic rsc_par1(input logic [2:0] s, input logic u);
    return rsc_w(s, u) ^ s[0] ^ s[1] ^ s[2];
  endfunction

endpackage

// File: rtl/tpe_pingpong.sv
`timescale 1ns/1ps
module tpe_pingpong #(
  parameter int SHORT_LEN = 16,
  parameter int LONG_LEN  = 48,
  parameter int MAX_LEN   = 48,
  parameter int AW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_bit,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          size_sel,
  input  logic          release_i,
  input  logic [AW-1:0] nat_addr,
  input  logic [AW-1:0] il_addr,
  output logic          ready_o,
  output logic          rd_full_o,
  output logic          rd_sel_len_o,
  output logic [1:0]    full_o,
  output logic          nat_bit_o,
  output logic          il_bit_o
);

  logic [MAX_LEN-1:0] mem_q [2];
  logic [1:0]         full_q;
  logic [1:0]         lsel_q;
  logic               wr_sel_q;
  logic               rd_sel_q;
  logic [AW-1:0]      wr_ptr_q;

  logic               accept;
  logic [AW-1:0]      ptr;
  logic               eff_sel;
  logic               last_bit;

  always_comb begin
    accept   = in_valid && !full_q[wr_sel_q];
    ptr      = in_first ? '0 : wr_ptr_q;
    eff_sel  = in_first ? size_sel : lsel_q[wr_sel_q];
    last_bit = (ptr == (eff_sel ? AW'(LONG_LEN - 1) : AW'(SHORT_LEN - 1)));
  end

  always_ff @(posedge clk) begin
    if (accept) mem_q[wr_sel_q][ptr] <= in_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= '0;
      lsel_q   <= '0;
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
      wr_ptr_q <= '0;
    end else if (clr) begin
      full_q   <= '0;
      lsel_q   <= '0;
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
      wr_ptr_q <= '0;
    end else begin
      if (accept) begin
        if (in_first) lsel_q[wr_sel_q] <= size_sel;
        if (last_bit) begin
          full_q[wr_sel_q] <= 1'b1;
          wr_sel_q         <= ~wr_sel_q;
          wr_ptr_q         <= '0;
        end else begin
          wr_ptr_q <= ptr + AW'(1);
        end
      end
      if (release_i) begin
        full_q[rd_sel_q] <= 1'b0;
        rd_sel_q         <= ~rd_sel_q;
      end
    end
  end

  assign ready_o      = !full_q[wr_sel_q];
  assign rd_full_o    = full_q[rd_sel_q];
  assign rd_sel_len_o = lsel_q[rd_sel_q];
  assign full_o       = full_q;
  assign nat_bit_o    = mem_q[rd_sel_q][nat_addr];
  assign il_bit_o     = mem_q[rd_sel_q][il_addr];

endmodule

// File: rtl/tpe_seq.sv
`timescale 1ns/1ps
module tpe_seq
  import tpe_pkg::*;
#(
  parameter int SHORT_LEN = 16,
  parameter int LONG_LEN  = 48,
  parameter int ROWS      = 4,
  parameter int AW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          blk_ready,
  input  logic          blk_sel,
  output tpe_phase_e    phase_o,
  output logic [AW-1:0] nat_addr_o,
  output logic [AW-1:0] il_addr_o,
  output logic          release_o,
  output logic          out_valid_o,
  output logic          out_tail_o,
  output logic          cur_sel_o
);

  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  tpe_phase_e    phase_q;
  logic [AW-1:0] idx_q;
  logic [AW-1:0] il_q;
  logic [AW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic [1:0]    tcnt_q;
  logic          cur_sel_q;
  logic          vld_q;
  logic          tail_q;

  logic [AW-1:0] last_idx;
  logic [AW-1:0] cols;
  logic          data_end;

  always_comb begin
    last_idx = cur_sel_q ? AW'(LONG_LEN - 1) : AW'(SHORT_LEN - 1);
    cols     = cur_sel_q ? AW'(LONG_LEN / ROWS) : AW'(SHORT_LEN / ROWS);
    data_end = (phase_q == PH_DATA) && (idx_q == last_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      idx_q     <= '0;
      il_q      <= '0;
      col_q     <= '0;
      row_q     <= '0;
      tcnt_q    <= '0;
      cur_sel_q <= 1'b0;
      vld_q     <= 1'b0;
      tail_q    <= 1'b0;
    end else if (clr) begin
      phase_q   <= PH_IDLE;
      idx_q     <= '0;
      il_q      <= '0;
      col_q     <= '0;
      row_q     <= '0;
      tcnt_q    <= '0;
      cur_sel_q <= 1'b0;
      vld_q     <= 1'b0;
      tail_q    <= 1'b0;
    end else begin
      vld_q  <= (phase_q != PH_IDLE);
      tail_q <= (phase_q == PH_TAIL);
      case (phase_q)
        PH_IDLE: begin
          if (blk_ready) begin
            phase_q   <= PH_DATA;
            idx_q     <= '0;
            il_q      <= '0;
            col_q     <= '0;
            row_q     <= '0;
            cur_sel_q <= blk_sel;
          end
        end
        PH_DATA: begin
          if (data_end) begin
            phase_q <= PH_TAIL;
            tcnt_q  <= '0;
          end else begin
            idx_q <= idx_q + AW'(1);
            if (row_q == RW'(ROWS - 1)) begin
              row_q <= '0;
              col_q <= col_q + AW'(1);
              il_q  <= col_q + AW'(1);
            end else begin
              row_q <= row_q + RW'(1);
              il_q  <= il_q + cols;
            end
          end
        end
        PH_TAIL: begin
          if (tcnt_q == 2'd2) phase_q <= PH_IDLE;
          else                tcnt_q  <= tcnt_q + 2'd1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o     = phase_q;
  assign nat_addr_o  = idx_q;
  assign il_addr_o   = il_q;
  assign release_o   = data_end;
  assign out_valid_o = vld_q;
  assign out_tail_o  = tail_q;
  assign cur_sel_o   = cur_sel_q;

endmodule

// File: rtl/tpe_rsc.sv
`timescale 1ns/1ps
module tpe_rsc
  import tpe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  tpe_phase_e phase,
  input  logic       u_in,
  output logic       sys_o,
  output logic       par0_o,
  output logic       par1_o,
  output logic       tail_o,
  output logic [2:0] state_o
);

  logic [2:0] st_q;
  logic       sys_q, p0_q, p1_q, tl_q;
  logic       tail_u;

  assign tail_u = rsc_fb(st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      sys_q <= 1'b0;
      p0_q  <= 1'b0;
      p1_q  <= 1'b0;
      tl_q  <= 1'b0;
    end else if (clr) begin
      st_q  <= '0;
      sys_q <= 1'b0;
      p0_q  <= 1'b0;
      p1_q  <= 1'b0;
      tl_q  <= 1'b0;
    end else begin
      case (phase)
        PH_DATA: begin
          st_q  <= rsc_next(st_q, u_in);
          sys_q <= u_in;
          p0_q  <= rsc_par0(st_q, u_in);
          p1_q  <= rsc_par1(st_q, u_in);
          tl_q  <= 1'b0;
        end
        PH_TAIL: begin
          st_q  <= rsc_next(st_q, tail_u);
          sys_q <= 1'b0;
          p0_q  <= rsc_par0(st_q, tail_u);
          p1_q  <= rsc_par1(st_q, tail_u);
          tl_q  <= tail_u;
        end
        default: begin
          st_q  <= '0;
          sys_q <= 1'b0;
          p0_q  <= 1'b0;
          p1_q  <= 1'b0;
          tl_q  <= 1'b0;
        end
      endcase
    end
  end

  assign sys_o   = sys_q;
  assign par0_o  = p0_q;
  assign par1_o  = p1_q;
  assign tail_o  = tl_q;
  assign state_o = st_q;

endmodule

// File: rtl/turbo_pcc_encoder.sv
`timescale 1ns/1ps
module turbo_pcc_encoder
  import tpe_pkg::*;
#(
  parameter int SHORT_LEN = 16,
  parameter int LONG_LEN  = 48,
  parameter int ROWS      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic in_bit,
  input  logic in_valid,
  input  logic in_first,
  input  logic size_sel,
  output logic ready,
  output logic out_valid,
  output logic nat_sys,
  output logic nat_par0,
  output logic nat_par1,
  output logic nat_tail,
  output logic il_sys,
  output logic il_par0,
  output logic il_par1,
  output logic il_tail
);

  localparam int MAX_LEN = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int AW      = $clog2(MAX_LEN);
  localparam int NENC    = 2;

  // named internal events, also observed by the bound checker
  tpe_phase_e    phase_w;
  logic [AW-1:0] nat_addr_w, il_addr_w;
  logic          release_w;
  logic          rd_full_w;
  logic          rd_len_w;
  logic [1:0]    buf_full_w;
  logic          nat_bit_w, il_bit_w;
  logic          out_tail_w;
  logic          cur_sel_w;
  logic [5:0]    enc_state_w;

  logic [NENC-1:0] u_w, sys_w, p0_w, p1_w, tl_w;

  tpe_pingpong #(
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .MAX_LEN(MAX_LEN), .AW(AW)
  ) buf_i (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .in_bit(in_bit), .in_valid(in_valid), .in_first(in_first), .size_sel(size_sel),
    .release_i(release_w), .nat_addr(nat_addr_w), .il_addr(il_addr_w),
    .ready_o(ready), .rd_full_o(rd_full_w), .rd_sel_len_o(rd_len_w),
    .full_o(buf_full_w), .nat_bit_o(nat_bit_w), .il_bit_o(il_bit_w)
  );

  tpe_seq #(
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .ROWS(ROWS), .AW(AW)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .blk_ready(rd_full_w), .blk_sel(rd_len_w),
    .phase_o(phase_w), .nat_addr_o(nat_addr_w), .il_addr_o(il_addr_w),
    .release_o(release_w), .out_valid_o(out_valid), .out_tail_o(out_tail_w),
    .cur_sel_o(cur_sel_w)
  );

  assign u_w = {il_bit_w, nat_bit_w};

  for (genvar g = 0; g < NENC; g++) begin : g_enc
    tpe_rsc rsc_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .phase(phase_w), .u_in(u_w[g]),
      .sys_o(sys_w[g]), .par0_o(p0_w[g]), .par1_o(p1_w[g]), .tail_o(tl_w[g]),
      .state_o(enc_state_w[3*g +: 3])
    );
  end

  assign nat_sys  = sys_w[0];
  assign nat_par0 = p0_w[0];
  assign nat_par1 = p1_w[0];
  assign nat_tail = tl_w[0];
  assign il_sys   = sys_w[1];
  assign il_par0  = p0_w[1];
  assign il_par1  = p1_w[1];
  assign il_tail  = tl_w[1];

endmodule

// File: rtl/tpe_checker.sv
`timescale 1ns/1ps
module tpe_checker #(
  parameter int SHORT_LEN = 16,
  parameter int LONG_LEN  = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       ready,
  input logic       out_valid,
  input logic       nat_sys,
  input logic       nat_par0,
  input logic       nat_par1,
  input logic       nat_tail,
  input logic       il_sys,
  input logic       il_par0,
  input logic       il_par1,
  input logic       il_tail,
  input logic       out_tail,
  input logic       blk_sel,
  input logic [1:0] buf_full,
  input logic [5:0] enc_state
);

  logic [7:0] run_q;
  logic       sel_l_q;
  logic       vld_prev_q;
  logic [7:0] exp_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      sel_l_q    <= 1'b0;
      vld_prev_q <= 1'b0;
    end else begin
      vld_prev_q <= out_valid;
      if (out_valid && !vld_prev_q) sel_l_q <= blk_sel;
      if (clr || !out_valid) run_q <= '0;
      else                   run_q <= run_q + 8'd1;
    end
  end

  assign exp_run = sel_l_q ? 8'(LONG_LEN + 3) : 8'(SHORT_LEN + 3);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> {nat_sys, nat_par0, nat_par1, nat_tail,
                    il_sys, il_par0, il_par1, il_tail} == 8'd0);

  // R2
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(out_valid) && !$past(clr)) |-> run_q == exp_run);

  // R7
  tail_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nat_tail || il_tail) |-> out_tail);

  // R7
  tail_sys_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tail |-> (!nat_sys && !il_sys));

  // R7
  tail_zero_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(out_tail) && !$past(clr)) |-> $past(enc_state) == 6'd0);

  // R8
  ready_both_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> buf_full == 2'b11);

  // R9
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!out_valid && ready));

endmodule

bind turbo_pcc_encoder tpe_checker #(
  .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ready(ready), .out_valid(out_valid),
  .nat_sys(nat_sys), .nat_par0(nat_par0), .nat_par1(nat_par1), .nat_tail(nat_tail),
  .il_sys(il_sys), .il_par0(il_par0), .il_par1(il_par1), .il_tail(il_tail),
  .out_tail(out_tail_w), .blk_sel(cur_sel_w), .buf_full(buf_full_w),
  .enc_state(enc_state_w)
);

// File: tb/turbo_pcc_encoder_tb.sv
`timescale 1ns/1ps
module turbo_pcc_encoder_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_bit = 1'b0;
  logic in_valid = 1'b0;
  logic in_first = 1'b0;
  logic size_sel = 1'b0;
  logic ready, out_valid;
  logic nat_sys, nat_par0, nat_par1, nat_tail;
  logic il_sys, il_par0, il_par1, il_tail;

  always #10 clk = ~clk;

  turbo_pcc_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_bit(in_bit), .in_valid(in_valid),
    .in_first(in_first), .size_sel(size_sel), .ready(ready), .out_valid(out_valid),
    .nat_sys(nat_sys), .nat_par0(nat_par0), .nat_par1(nat_par1), .nat_tail(nat_tail),
    .il_sys(il_sys), .il_par0(il_par0), .il_par1(il_par1), .il_tail(il_tail)
  );

  // vector: {expected length [56:49], size select [48], data [47:0]}, bit 0 sent first
  localparam logic [56:0] VECS [4] = '{
    {8'd16, 1'b0, 48'h0000_0000_A5C3},
    {8'd48, 1'b1, 48'h9E37_79B9_7F4A},
    {8'd16, 1'b0, 48'h0000_0000_0001},
    {8'd48, 1'b1, 48'hFFFF_FFFF_FFFF}
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] cap [0:1023];
  int cap_n = 0;
  int runs [0:63];
  int run_n = 0;
  int cur_run = 0;

  always @(negedge clk) begin
    if (out_valid) begin
      cap[cap_n] = {nat_sys, nat_par0, nat_par1, nat_tail, il_sys, il_par0, il_par1, il_tail};
      cap_n = cap_n + 1;
      cur_run = cur_run + 1;
    end else if (cur_run != 0) begin
      runs[run_n] = cur_run;
      run_n = run_n + 1;
      cur_run = 0;
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic send_block(input logic [47:0] d, input logic sel, input int n);
    for (int i = 0; i < n; i++) begin
      while (!ready) @(negedge clk);
      in_valid = 1'b1;
      in_bit   = d[i];
      in_first = (i == 0);
      size_sel = sel;
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_first = 1'b0;
  endtask

  task automatic wait_runs(input int target);
    for (int t = 0; t < 3000 && run_n < target; t++) @(negedge clk);
    @(negedge clk);
    chk("R3", "valid run finished", int'(run_n >= target), 1);
  endtask

  task automatic check_block(input logic [47:0] d, input int len, input int base, input int ridx);
    int mis_ns, mis_is, mis_par, mis_tl;
    logic r1, r2, r3, u, w, p0, p1, es, et;
    logic [7:0] g;
    mis_ns = 0; mis_is = 0; mis_par = 0; mis_tl = 0;
    for (int e = 0; e < 2; e++) begin
      r1 = 0; r2 = 0; r3 = 0;
      for (int k = 0; k < len + 3; k++) begin
        if (k < len) u = (e == 0) ? d[k] : d[(k % 4) * (len / 4) + k / 4];
        else         u = r2 ^ r3;
        w  = u ^ r2 ^ r3;
        p0 = w ^ r1 ^ r3;
        p1 = w ^ r1 ^ r2 ^ r3;
        es = (k < len) ? u : 1'b0;
        et = (k < len) ? 1'b0 : u;
        g  = cap[base + k];
        if (e == 0) begin
          if (g[7] != es) mis_ns++;
          if (g[6] != p0 || g[5] != p1) mis_par++;
          if (g[4] != et) mis_tl++;
        end else begin
          if (g[3] != es) mis_is++;
          if (g[2] != p0 || g[1] != p1) mis_par++;
          if (g[0] != et) mis_tl++;
        end
        r3 = r2; r2 = r1; r1 = w;
      end
    end
    chk("R2", "valid run length", runs[ridx], len + 3);
    chk("R4", "natural systematic mismatches", mis_ns, 0);
    chk("R5", "interleaved systematic mismatches", mis_is, 0);
    chk("R6", "parity mismatches", mis_par, 0);
    chk("R7", "tail mismatches", mis_tl, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, rb, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ready after reset", ready, 1);
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R3", "outputs quiet after reset",
        {nat_sys, nat_par0, nat_par1, nat_tail, il_sys, il_par0, il_par1, il_tail}, 0);

    // table walk: one block per vector
    for (int v = 0; v < 4; v++) begin
      base = cap_n;
      rb   = run_n;
      send_block(VECS[v][47:0], VECS[v][48], int'(VECS[v][56:49]));
      wait_runs(rb + 1);
      check_block(VECS[v][47:0], int'(VECS[v][56:49]), base, rb);
    end

    // R8 back-to-back blocks, refused input while both halves are occupied
    base = cap_n;
    rb   = run_n;
    send_block(48'h1234_5678_9ABC, 1'b1, 48);
    send_block(48'h0000_0000_C0DE, 1'b0, 16);
    chk("R1", "ready low with both halves full", ready, 0);
    for (int j = 0; j < 4; j++) begin
      in_valid = 1'b1; in_first = 1'b1; in_bit = 1'b1; size_sel = 1'b1;
      @(negedge clk);
      chk("R8", "ready stays low while refusing", ready, 0);
    end
    in_valid = 1'b0; in_first = 1'b0;
    wait_runs(rb + 2);
    check_block(48'h1234_5678_9ABC, 48, base, rb);
    check_block(48'h0000_0000_C0DE, 16, base + 51, rb + 1);

    // R9 clear during encoding
    rb = run_n;
    send_block(48'hDEAD_BEEF_0F0F, 1'b1, 48);
    repeat (10) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R9", "out_valid after clear", out_valid, 0);
    chk("R9", "ready after clear", ready, 1);
    repeat (2) @(negedge clk);
    c0 = cap_n;
    repeat (80) @(negedge clk);
    chk("R9", "no output after clear", cap_n - c0, 0);
    chk("R9", "only the cut run recorded", run_n - rb, 1);

    // R9 clear with a partly written block, then a clean block
    send_block(48'hFFFF_FFFF_FFFF, 1'b1, 10);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    base = cap_n;
    rb   = run_n;
    send_block(48'h0000_0000_3C69, 1'b0, 16);
    wait_runs(rb + 1);
    check_block(48'h0000_0000_3C69, 16, base, rb);
    chk("R9", "single block after partial clear", run_n - rb, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule